// File: doc/BRIEF.md
# Oversampling Serial Character Receiver with Address Wake-Up

This block turns an asynchronous serial line into characters. A clock enable that pulses sixteen times per bit period paces it. A falling edge on the idle-high line starts a frame. Half a bit later the line is checked again, and if it has gone back high the edge is dropped as noise. After that, each following bit is sampled at its centre. Characters arrive least significant bit first and hold 5 to 8 data bits. An optional wake-up bit follows them, then an optional parity bit, then the stop bit. At the stop-bit centre the block raises a one-cycle frame-end strobe, together with pulses that classify the frame. An all-zero frame whose stop bit is also low is reported as a line break.

The holding register keeps the last delivered character until the consumer acknowledges it. In multi-drop networks, wake-up mode marks address characters with an extra bit. These are compared against the node address without any software involvement, and data characters are thrown away until an address matches. A character-search comparator flags delivered characters that equal a programmed value.

Top module: `uwr_rx`

## Requirements
- R1: After reset, rx_valid is low and every event output (rx_done, err_frame, err_parity, err_overrun, brk_det, addr_hit, chr_hit) is low.
- R2: A low level seen on a tick while idle is confirmed 8 ticks later. If the line is high at that point, the edge is dropped, no frame-end strobe follows, and the receiver hunts again.
- R3: cfg_len codes 0, 1, 2, 3 select 5, 6, 7, 8 data bits, sent LSB first. rx_data holds the character right-aligned, with the unused upper bits at zero.
- R4: cfg_par selects 01 even, 10 odd, and 00 or 11 none. The parity bit covers the data bits only and comes after the wake-up bit when both are present. A mismatch pulses err_parity.
- R5: A low stop bit on a frame that is not a break pulses err_frame, and the character is still delivered.
- R6: A frame in which the data, any wake-up bit, any parity bit and the stop bit are all zero pulses brk_det, with no frame or parity error and no delivery. No new start is hunted until the line has returned high.
- R7: If a character is delivered while rx_valid is set and rd_ack is low, err_overrun pulses and the held character is kept.
- R8: rd_ack clears rx_valid. rd_ack while rx_valid is low has no effect.
- R9: With cfg_wake set, each frame carries one extra bit after the data bits. A 1 in that bit marks an address character and a 0 marks a data character.
- R10: An address character is compared with cfg_addr, masked to the character length. A match pulses addr_hit and wakes the node, a mismatch puts it to sleep, and address characters are never delivered.
- R11: In wake-up mode, data characters are delivered only while the node is awake and are otherwise discarded, with only rx_done pulsing. Clearing cfg_wake returns the node to sleep.
- R12: With cfg_srch_en set, chr_hit pulses when a character loaded into the holding register equals cfg_srch_chr masked to the character length.
- R13: Every event output is a one-cycle pulse and appears only in the same cycle as rx_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable, sixteen pulses per bit period |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Character length code |
| cfg_par | input | 2 | Parity mode code |
| cfg_wake | input | 1 | Wake-up bit framing and address filtering |
| cfg_addr | input | 8 | Node address |
| cfg_srch_en | input | 1 | Character search enable |
| cfg_srch_chr | input | 8 | Character searched for |
| rd_ack | input | 1 | Consumer has taken rx_data |
| rx_data | output | 8 | Held character |
| rx_valid | output | 1 | Holding register full |
| rx_done | output | 1 | Frame-end strobe |
| err_frame | output | 1 | Framing error pulse |
| err_parity | output | 1 | Parity error pulse |
| err_overrun | output | 1 | Overrun pulse |
| brk_det | output | 1 | Line break pulse |
| addr_hit | output | 1 | Address match pulse |
| chr_hit | output | 1 | Search match pulse |

## Verification
The assertions check, on every cycle, the relations that need no knowledge of the bits on the wire. Events only ever come with the frame-end strobe. A break excludes the error and match pulses. An overrun leaves the held character untouched, and an acknowledge empties the holding register. A rejected start sends the receiver back to idle, and a data character in wake-up mode reaches the holding register only while the node is awake. Only the bench scenarios can show that the sampled bits, the parity, the break and framing decisions and the address comparisons are correct for real frames. These scenarios cover every length, both parity senses, a glitch, a held break and a full sleep-wake-sleep sequence.

// File: rtl/uwr_pkg.sv
`timescale 1ns/1ps
package uwr_pkg;

  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_DATA, PH_WAKE, PH_PAR, PH_STOP, PH_HOLD
  } rx_phase_e;

  // Captured frame, handed from the deframer to the classifier.
  typedef struct packed {
    logic [CHAR_W-1:0] data;  // right-aligned character
    logic              wbit;  // wake-up bit (0 when absent)
    logic              pbit;  // parity bit (0 when absent)
    logic              sbit;  // stop bit
    logic [1:0]        len;   // length code in force for the frame
    logic [1:0]        par;   // parity code in force for the frame
    logic              wake;  // wake-up framing in force for the frame
  } frame_t;

  // Index of the last data bit for a length code (5..8 bits).
  function automatic logic [2:0] last_idx(input logic [1:0] code);
    return 3'd4 + {1'b0, code};
  endfunction

  // Mask keeping the valid character bits for a length code.
  function automatic logic [CHAR_W-1:0] len_mask(input logic [1:0] code);
    return {CHAR_W{1'b1}} >> (2'd3 - code);
  endfunction

  // Bits shift in at the top; move the character down to bit 0.
  function automatic logic [CHAR_W-1:0] align(input logic [CHAR_W-1:0] sh,
                                               input logic [1:0] code);
    return sh >> (2'd3 - code);
  endfunction

  function automatic logic par_on(input logic [1:0] code);
    return code == 2'b01 || code == 2'b10;
  endfunction

  // Parity bit a correct sender puts on the line.
  function automatic logic par_expect(input logic [CHAR_W-1:0] d,
                                      input logic [1:0] code);
    return (^d) ^ (code == 2'b10);
  endfunction

endpackage

// File: rtl/uwr_sync.sv
`timescale 1ns/1ps
module uwr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uwr_deframer.sv
`timescale 1ns/1ps
module uwr_deframer import uwr_pkg::*; #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_s,
  input  logic [1:0] cfg_len,
  input  logic [1:0] cfg_par,
  input  logic       cfg_wake,
  output frame_t     frm,
  output logic       frm_stb,
  output logic       samp_stb,
  output logic       start_reject,
  output logic       busy
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] FIN = CW'(OSR - 1);

  rx_phase_e          ph;
  logic [CW-1:0]      cnt;
  logic [2:0]         idx;
  logic [CHAR_W-1:0]  sh;
  logic               wbit, pbit, sbit;
  logic [1:0]         l_len, l_par;
  logic               l_wake;
  logic               at_mid, at_fin, in_bit;

  assign in_bit       = ph == PH_DATA || ph == PH_WAKE || ph == PH_PAR || ph == PH_STOP;
  assign at_mid       = tick && ph == PH_START && cnt == MID;
  assign at_fin       = tick && in_bit && cnt == FIN;
  assign samp_stb     = at_mid || at_fin;
  assign start_reject = at_mid && rx_s;
  assign busy         = ph != PH_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      idx     <= '0;
      sh      <= '0;
      wbit    <= 1'b0;
      pbit    <= 1'b0;
      sbit    <= 1'b1;
      l_len   <= 2'b11;
      l_par   <= 2'b00;
      l_wake  <= 1'b0;
      frm_stb <= 1'b0;
    end else begin
      frm_stb <= 1'b0;
      if (tick) begin
        case (ph)
          PH_IDLE: begin
            cnt <= '0;
            if (!rx_s) begin
              ph     <= PH_START;
              l_len  <= cfg_len;
              l_par  <= cfg_par;
              l_wake <= cfg_wake;
              wbit   <= 1'b0;
              pbit   <= 1'b0;
            end
          end
          PH_START: begin
            if (cnt == MID) begin
              cnt <= '0;
              idx <= '0;
              ph  <= rx_s ? PH_IDLE : PH_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_DATA: begin
            if (cnt == FIN) begin
              cnt <= '0;
              sh  <= {rx_s, sh[CHAR_W-1:1]};
              if (idx == last_idx(l_len)) begin
                if (l_wake)             ph <= PH_WAKE;
                else if (par_on(l_par)) ph <= PH_PAR;
                else                    ph <= PH_STOP;
              end else begin
                idx <= idx + 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_WAKE: begin
            if (cnt == FIN) begin
              cnt  <= '0;
              wbit <= rx_s;
              ph   <= par_on(l_par) ? PH_PAR : PH_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_PAR: begin
            if (cnt == FIN) begin
              cnt  <= '0;
              pbit <= rx_s;
              ph   <= PH_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_STOP: begin
            if (cnt == FIN) begin
              cnt     <= '0;
              sbit    <= rx_s;
              frm_stb <= 1'b1;
              ph      <= rx_s ? PH_IDLE : PH_HOLD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_HOLD: begin
            cnt <= '0;
            if (rx_s) ph <= PH_IDLE;
          end
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    frm.data = align(sh, l_len);
    frm.wbit = wbit;
    frm.pbit = pbit;
    frm.sbit = sbit;
    frm.len  = l_len;
    frm.par  = l_par;
    frm.wake = l_wake;
  end
endmodule

// File: rtl/uwr_classify.sv
`timescale 1ns/1ps
module uwr_classify import uwr_pkg::*; (
  input  frame_t            frm,
  input  logic [CHAR_W-1:0] cfg_addr,
  input  logic              cfg_srch_en,
  input  logic [CHAR_W-1:0] cfg_srch_chr,
  input  logic              awake,
  output logic              brk,
  output logic              ferr,
  output logic              perr,
  output logic              is_addr,
  output logic              addr_eq,
  output logic              deliver,
  output logic              chr_eq
);
  logic [CHAR_W-1:0] mask;
  logic              pon;

  always_comb begin
    mask    = len_mask(frm.len);
    pon     = par_on(frm.par);
    brk     = frm.data == '0 && !(frm.wake && frm.wbit) &&
              !(pon && frm.pbit) && !frm.sbit;
    ferr    = !frm.sbit && !brk;
    perr    = pon && !brk && (frm.pbit != par_expect(frm.data, frm.par));
    is_addr = frm.wake && frm.wbit && !brk;
    addr_eq = is_addr && frm.data == (cfg_addr & mask);
    deliver = !brk && !(frm.wake && frm.wbit) && (!frm.wake || awake);
    chr_eq  = deliver && cfg_srch_en && frm.data == (cfg_srch_chr & mask);
  end
endmodule

// File: rtl/uwr_hold.sv
`timescale 1ns/1ps
module uwr_hold import uwr_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_stb,
  input  logic              rd_ack,
  input  logic              cfg_wake,
  input  logic [CHAR_W-1:0] data_in,
  input  logic              brk,
  input  logic              ferr,
  input  logic              perr,
  input  logic              is_addr,
  input  logic              addr_eq,
  input  logic              deliver,
  input  logic              chr_eq,
  output logic              awake,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_done,
  output logic              err_frame,
  output logic              err_parity,
  output logic              err_overrun,
  output logic              brk_det,
  output logic              addr_hit,
  output logic              chr_hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      awake       <= 1'b0;
      rx_data     <= '0;
      rx_valid    <= 1'b0;
      rx_done     <= 1'b0;
      err_frame   <= 1'b0;
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
      brk_det     <= 1'b0;
      addr_hit    <= 1'b0;
      chr_hit     <= 1'b0;
    end else begin
      rx_done     <= 1'b0;
      err_frame   <= 1'b0;
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
      brk_det     <= 1'b0;
      addr_hit    <= 1'b0;
      chr_hit     <= 1'b0;
      if (!cfg_wake) awake <= 1'b0;
      if (rd_ack)    rx_valid <= 1'b0;
      if (frm_stb) begin
        rx_done    <= 1'b1;
        brk_det    <= brk;
        err_frame  <= ferr;
        err_parity <= perr;
        addr_hit   <= addr_eq;
        if (is_addr) awake <= addr_eq;
        if (deliver) begin
          if (rx_valid && !rd_ack) begin
            err_overrun <= 1'b1;
          end else begin
            rx_data  <= data_in;
            rx_valid <= 1'b1;
            chr_hit  <= chr_eq;
          end
        end
      end
    end
  end
endmodule

// File: rtl/uwr_rx.sv
`timescale 1ns/1ps
module uwr_rx import uwr_pkg::*; #(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic [1:0]        cfg_len,
  input  logic [1:0]        cfg_par,
  input  logic              cfg_wake,
  input  logic [CHAR_W-1:0] cfg_addr,
  input  logic              cfg_srch_en,
  input  logic [CHAR_W-1:0] cfg_srch_chr,
  input  logic              rd_ack,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_done,
  output logic              err_frame,
  output logic              err_parity,
  output logic              err_overrun,
  output logic              brk_det,
  output logic              addr_hit,
  output logic              chr_hit
);
  logic   rx_s;
  frame_t frm;
  logic   frm_stb, samp_stb, start_reject, busy;
  logic   c_brk, c_ferr, c_perr, c_is_addr, c_addr_eq, c_deliver, c_chr_eq;
  logic   awake;
  logic   dlv_stb;

  uwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
  );

  uwr_deframer #(.OSR(OSR)) u_deframer (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rx_s(rx_s),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_wake(cfg_wake),
    .frm(frm), .frm_stb(frm_stb), .samp_stb(samp_stb),
    .start_reject(start_reject), .busy(busy)
  );

  uwr_classify u_classify (
    .frm(frm), .cfg_addr(cfg_addr), .cfg_srch_en(cfg_srch_en),
    .cfg_srch_chr(cfg_srch_chr), .awake(awake),
    .brk(c_brk), .ferr(c_ferr), .perr(c_perr), .is_addr(c_is_addr),
    .addr_eq(c_addr_eq), .deliver(c_deliver), .chr_eq(c_chr_eq)
  );

  assign dlv_stb = frm_stb && c_deliver;

  uwr_hold u_hold (
    .clk(clk), .rst_n(rst_n), .frm_stb(frm_stb), .rd_ack(rd_ack),
    .cfg_wake(cfg_wake), .data_in(frm.data),
    .brk(c_brk), .ferr(c_ferr), .perr(c_perr), .is_addr(c_is_addr),
    .addr_eq(c_addr_eq), .deliver(c_deliver), .chr_eq(c_chr_eq),
    .awake(awake), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_done(rx_done), .err_frame(err_frame), .err_parity(err_parity),
    .err_overrun(err_overrun), .brk_det(brk_det), .addr_hit(addr_hit),
    .chr_hit(chr_hit)
  );
endmodule

// File: rtl/uwr_rx_chk.sv
`timescale 1ns/1ps
module uwr_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick16,
  input logic       rd_ack,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       rx_done,
  input logic       err_frame,
  input logic       err_parity,
  input logic       err_overrun,
  input logic       brk_det,
  input logic       addr_hit,
  input logic       chr_hit,
  input logic       samp_stb,
  input logic       start_reject,
  input logic       busy,
  input logic       dlv_stb,
  input logic       frm_wake,
  input logic       awake
);
  // R13: events travel with the frame-end strobe
  a_r13_events_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (err_frame || err_parity || err_overrun || brk_det || addr_hit || chr_hit) |-> rx_done);

  // R13: the strobe lasts one cycle
  a_r13_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  // R6: a break carries no error or match
  a_r6_break_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    brk_det |-> (!err_frame && !err_parity && !addr_hit && !chr_hit));

  // R7: overrun keeps the held character
  a_r7_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    err_overrun |-> (rx_valid && $stable(rx_data)));

  // R8: acknowledge empties the holding register unless a new one lands
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rd_ack) |=> (!rx_valid || rx_done));

  // R2: samples happen only on ticks, and a rejected start returns to idle
  a_r2_sample_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    samp_stb |-> tick16);

  a_r2_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_reject |=> !busy);

  // R11: in wake-up mode only an awake node takes data
  a_r11_sleep_discards: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_stb && frm_wake) |-> awake);

  // R10: an address hit leaves the node awake
  a_r10_hit_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |-> awake);

  // R12: a search hit refers to a freshly loaded character
  a_r12_hit_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    chr_hit |-> (rx_valid && !err_overrun));
endmodule

bind uwr_rx uwr_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .rd_ack(rd_ack),
  .rx_data(rx_data), .rx_valid(rx_valid), .rx_done(rx_done),
  .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun),
  .brk_det(brk_det), .addr_hit(addr_hit), .chr_hit(chr_hit),
  .samp_stb(samp_stb), .start_reject(start_reject), .busy(busy),
  .dlv_stb(dlv_stb), .frm_wake(frm.wake), .awake(awake)
);

// File: tb/tb_uwr_rx.sv
`timescale 1ns/1ps
module tb_uwr_rx;
  localparam int OSR  = 16;
  localparam int TDIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic [1:0] cfg_par = 2'd0;
  logic       cfg_wake = 1'b0;
  logic [7:0] cfg_addr = 8'h00;
  logic       cfg_srch_en = 1'b0;
  logic [7:0] cfg_srch_chr = 8'h00;
  logic       rd_ack = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, rx_done, err_frame, err_parity, err_overrun;
  logic       brk_det, addr_hit, chr_hit;

  always #4 clk = ~clk;

  uwr_rx dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_wake(cfg_wake),
    .cfg_addr(cfg_addr), .cfg_srch_en(cfg_srch_en), .cfg_srch_chr(cfg_srch_chr),
    .rd_ack(rd_ack), .rx_data(rx_data), .rx_valid(rx_valid), .rx_done(rx_done),
    .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun),
    .brk_det(brk_det), .addr_hit(addr_hit), .chr_hit(chr_hit)
  );

  int n_checks = 0;
  int n_fails  = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // tick generator
  int tcnt = 0;
  always @(negedge clk) begin
    tick16 <= (tcnt == 0);
    tcnt   <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
  end

  // reference model
  typedef struct packed {
    logic brk, ferr, perr, ahit, chr, dlv;
    logic [7:0] data;
  } exp_t;
  exp_t  q[$];
  string tq[$];
  bit    m_awake = 1'b0;
  bit    m_full  = 1'b0;
  logic [7:0] m_data = 8'h00;
  bit    ack_seen = 1'b0;
  bit    run_chk  = 1'b0;

  always @(posedge clk) ack_seen <= rd_ack;

  always @(negedge clk) begin
    if (run_chk) begin
      exp_t  e;
      string t;
      bit    ovr;
      if (ack_seen) m_full = 1'b0;
      if (rx_done) begin
        if (q.size() == 0) begin
          chk("R2", "unexpected frame end", 1, 0);
        end else begin
          e = q.pop_front();
          t = tq.pop_front();
          ovr = e.dlv && m_full;
          chk(t, "break", brk_det, e.brk);
          chk(t, "frame error", err_frame, e.ferr);
          chk(t, "parity error", err_parity, e.perr);
          chk(t, "address hit", addr_hit, e.ahit);
          chk(t, "search hit", chr_hit, e.chr && !ovr);
          chk("R7", "overrun", err_overrun, ovr);
          if (e.dlv && !ovr) begin
            m_full = 1'b1;
            m_data = e.data;
          end
        end
      end else begin
        // R13: no event without the frame-end strobe
        chk("R13", "stray event",
            int'({err_frame, err_parity, err_overrun, brk_det, addr_hit, chr_hit}), 0);
      end
      chk("R8", "rx_valid", rx_valid, m_full);
      if (m_full) chk("R3", "rx_data", rx_data, m_data);
    end
  end

  task automatic drive_bit(input logic v);
    rxd = v;
    repeat (OSR * TDIV) @(negedge clk);
  endtask

  task automatic rd();
    @(negedge clk) rd_ack = 1'b1;
    @(negedge clk) rd_ack = 1'b0;
  endtask

  task automatic send_char(input logic [7:0] d_in, input bit wb, input bit bad_par,
                           input bit stop_v, input int hold_low, input string tag);
    int         n;
    int         ones;
    logic [7:0] m;
    logic [7:0] d;
    bit         pon, pb, br;
    exp_t       e;
    n    = 5 + int'(cfg_len);
    m    = 8'((1 << n) - 1);
    d    = d_in & m;
    ones = 0;
    for (int i = 0; i < n; i++) ones += int'(d[i]);
    pon = (cfg_par == 2'd1) || (cfg_par == 2'd2);
    pb  = (cfg_par == 2'd2) ? ((ones % 2) == 0) : ((ones % 2) == 1);
    if (bad_par) pb = !pb;
    br  = (d == 8'h00) && !(cfg_wake && wb) && !(pon && pb) && !stop_v;
    e = '0;
    e.data = d;
    if (br) begin
      e.brk = 1'b1;
    end else begin
      e.ferr = !stop_v;
      e.perr = pon && bad_par;
      if (cfg_wake && wb) begin
        e.ahit  = (d == (cfg_addr & m));
        m_awake = e.ahit;
      end else begin
        e.dlv = !cfg_wake || m_awake;
        e.chr = e.dlv && cfg_srch_en && (d == (cfg_srch_chr & m));
      end
    end
    q.push_back(e);
    tq.push_back(tag);
    drive_bit(1'b0);
    for (int i = 0; i < n; i++) drive_bit(d[i]);
    if (cfg_wake) drive_bit(wb);
    if (pon) drive_bit(pb);
    drive_bit(stop_v);
    for (int i = 0; i < hold_low; i++) drive_bit(1'b0);
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    // R1: reset state
    chk("R1", "rx_valid at reset", rx_valid, 0);
    chk("R1", "events at reset",
        int'({rx_done, err_frame, err_parity, err_overrun, brk_det, addr_hit, chr_hit}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_chk = 1'b1;

    // R8: acknowledge on an empty register changes nothing
    rd();
    repeat (4) @(negedge clk);

    // R3: 8-bit, no parity
    send_char(8'hA5, 0, 0, 1, 0, "R3");
    rd();
    // R3: 7-bit character, upper bits dropped
    cfg_len = 2'd2;
    send_char(8'hD5, 0, 0, 1, 0, "R3");
    rd();
    // R4: 5-bit even parity, 6-bit odd parity
    cfg_len = 2'd0; cfg_par = 2'd1;
    send_char(8'h13, 0, 0, 1, 0, "R4");
    rd();
    cfg_len = 2'd1; cfg_par = 2'd2;
    send_char(8'h2A, 0, 0, 1, 0, "R4");
    rd();
    // R4: wrong parity bit on a 7-bit even frame
    cfg_len = 2'd2; cfg_par = 2'd1;
    send_char(8'h55, 0, 1, 1, 0, "R4");
    rd();
    // R4: code 11 means no parity
    cfg_len = 2'd3; cfg_par = 2'd3;
    send_char(8'h0F, 0, 0, 1, 0, "R4");
    rd();
    cfg_par = 2'd0;

    // R5: low stop bit on a non-zero frame
    send_char(8'h3C, 0, 0, 0, 0, "R5");
    rd();

    // R6: held break, then a normal character
    send_char(8'h00, 0, 0, 0, 3, "R6");
    send_char(8'h99, 0, 0, 1, 0, "R6");
    rd();

    // R2: glitch shorter than half a bit is ignored
    rxd = 1'b0;
    repeat (3 * TDIV) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * OSR * TDIV) @(negedge clk);
    chk("R2", "frames pending after glitch", q.size(), 0);
    send_char(8'h5E, 0, 0, 1, 0, "R2");
    rd();

    // R7: second character while the first is unread
    send_char(8'h81, 0, 0, 1, 0, "R7");
    send_char(8'h42, 0, 0, 1, 0, "R7");
    rd();

    // R12: character search hit and miss
    cfg_srch_en = 1'b1; cfg_srch_chr = 8'h3C;
    send_char(8'h3C, 0, 0, 1, 0, "R12");
    rd();
    send_char(8'h3D, 0, 0, 1, 0, "R12");
    rd();
    cfg_srch_en = 1'b0;

    // R9 R10 R11: wake-up sequence
    cfg_wake = 1'b1; cfg_addr = 8'h5A;
    send_char(8'h11, 0, 0, 1, 0, "R11");
    send_char(8'h33, 1, 0, 1, 0, "R10");
    send_char(8'h22, 0, 0, 1, 0, "R11");
    send_char(8'h5A, 1, 0, 1, 0, "R10");
    send_char(8'h77, 0, 0, 1, 0, "R9");
    rd();
    send_char(8'h5B, 1, 0, 1, 0, "R10");
    send_char(8'h44, 0, 0, 1, 0, "R11");
    // R10: 5-bit address compare is masked; parity follows wake bit (R4)
    cfg_len = 2'd0; cfg_par = 2'd2; cfg_addr = 8'hFA;
    send_char(8'h1A, 1, 0, 1, 0, "R10");
    send_char(8'h09, 0, 0, 1, 0, "R9");
    rd();
    // R11: leaving wake-up mode puts the node to sleep
    cfg_wake = 1'b0; m_awake = 1'b0;
    cfg_len = 2'd3; cfg_par = 2'd0;
    send_char(8'h66, 0, 0, 1, 0, "R11");
    rd();
    cfg_wake = 1'b1;
    send_char(8'h67, 0, 0, 1, 0, "R11");
    cfg_wake = 1'b0;

    repeat (2 * OSR * TDIV) @(negedge clk);
    chk("R13", "frames still expected", q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule